// File: doc/BRIEF.md
# Serial Clock Generator with Power-of-Two Prescaler

This block produces the serial clock for a flash-oriented SPI master from a faster reference clock. A transfer begins when a bit-shift request is accepted on a valid/ready handshake. The block then emits exactly two serial clock edges per requested bit. At each point where the data path must act, it raises a one-cycle strobe. A launch strobe means the next bit must be driven. A sample strobe means the incoming bit must be captured. The shift registers and chip select live outside this block and only watch these strobes.

A six-bit configuration word sets the behaviour:
- Bit 0 enables the master.
- Bit 1 sets the clock idle level (polarity).
- Bit 2 selects the phase.
- Bits 5:3 hold a divide code `c`. Code `c` divides the reference clock by `2 << c`, so the serial clock runs from half the reference rate (code 0) down to 1/256 (code 7). A host that picks the smallest code whose rate does not exceed its target never runs the flash too fast.

The request handshake applies back-pressure with `start_ready`. That signal is high only while the block is idle and the master is enabled. A request is taken on any cycle where `start_valid` and `start_ready` are both high. A requester may hold `start_valid` high, and its next request is then taken as soon as the block frees up. The divide code and phase are captured when a request is taken.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted, `sclk`, `launch_stb` and `sample_stb` are 0. With the master disabled (cfg bit 0 = 0), `start_ready` is 0.
- R2: With divide code `c` in cfg bits 5:3, every serial clock level lasts exactly `1 << c` reference cycles. The first edge comes `1 << c` cycles after the cycle in which the request is taken. Code 0 gives half the reference rate and code 7 gives 1/256 of it.
- R3: While idle with the master enabled, `sclk` takes the value of cfg bit 1 one cycle later. After the last edge of a transfer, `sclk` is back at that level.
- R4: With phase 0 (cfg bit 2 = 0), `launch_stb` pulses in the cycle after the request is taken and with every even edge except the last one. `sample_stb` pulses with every odd edge.
- R5: With phase 1, `launch_stb` pulses with every odd edge and `sample_stb` pulses with every even edge.
- R6: `start_ready` equals (master enabled and not transferring). A request of N bits makes exactly 2N edges. `start_ready` returns high in the cycle that shows the last edge, so a held `start_valid` starts the next transfer in the following cycle.
- R7: While cfg bit 0 is 0, `sclk` does not change and no request is taken. A transfer that is interrupted this way pauses and resumes without losing or shortening a half period.
- R8: Changes to the divide code, phase or polarity while a transfer runs have no effect on that transfer's timing, strobes or edge levels.
- R9: A request with a bit count of 0 is taken, produces no edges and no strobes, and leaves `start_ready` high.
- R10: `launch_stb` and `sample_stb` are never high together. Every `sample_stb` pulse coincides with a change of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 6 | {divide code[2:0], phase, polarity, master enable} |
| start_valid | input | 1 | Shift request present |
| start_ready | output | 1 | Block can take a request |
| start_bits | input | 8 | Number of bits in the request |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | Drive next bit this cycle |
| sample_stb | output | 1 | Capture incoming bit this cycle |

## Verification
Transfers are run with the fastest code, a middle code and the slowest code. This separates an exact half-period count from an off-by-one divider. Both phases are run with both polarities, which shows whether the strobes are bound to odd or even edges and whether the idle level is restored. A held request checks the back-to-back handoff, and a zero-length request checks the empty case. The configuration is changed while a transfer runs to show that the latched settings win. Mid-transfer disables, and requests made while disabled, show that the clock freezes and resumes with the same remaining half-period length.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_CPOL_BIT = 1;
  localparam int CFG_CPHA_BIT = 2;
  localparam int CFG_CODE_LSB = 3;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_SHIFT = 1'b1} seq_state_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int CODE_W = 3,
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] last;

  // half period is 1 << code reference cycles
  assign last = (HALF_W'(1) << code) - HALF_W'(1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/spi_edge_seq.sv
module spi_edge_seq
  import spi_sclk_pkg::*;
#(
  parameter int BITS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BITS_W-1:0] nbits,
  input  logic              cpha_in,
  input  logic              cpol_in,
  input  logic              en,
  input  logic              tick,
  output logic              sclk,
  output logic              launch_stb,
  output logic              sample_stb,
  output logic              busy
);
  localparam int EDGE_W = BITS_W + 1;

  seq_state_e        state;
  logic [EDGE_W-1:0] edges;
  logic [EDGE_W-1:0] total;
  logic [EDGE_W-1:0] next_edge;
  logic              cpha_q;
  logic              odd_edge;
  logic              last_edge;

  assign next_edge = edges + EDGE_W'(1);
  assign odd_edge  = ~edges[0];
  assign last_edge = (next_edge == total);
  assign busy      = (state == SEQ_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      edges      <= '0;
      total      <= '0;
      cpha_q     <= 1'b0;
      sclk       <= 1'b0;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
      if (accept) begin
        sclk <= cpol_in;
        if (nbits != '0) begin
          state      <= SEQ_SHIFT;
          edges      <= '0;
          total      <= {nbits, 1'b0};
          cpha_q     <= cpha_in;
          launch_stb <= ~cpha_in;
        end
      end else if (busy && en && tick) begin
        sclk  <= ~sclk;
        edges <= next_edge;
        if (odd_edge) begin
          sample_stb <= ~cpha_q;
          launch_stb <= cpha_q;
        end else begin
          sample_stb <= cpha_q;
          launch_stb <= ~cpha_q && !last_edge;
        end
        if (last_edge) state <= SEQ_IDLE;
      end else if (!busy && en) begin
        sclk <= cpol_in;
      end
    end
  end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int BITS_W = 8,
  localparam int CFG_W  = CFG_CODE_LSB + CODE_W,
  localparam int HALF_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [BITS_W-1:0] start_bits,
  output logic              sclk,
  output logic              launch_stb,
  output logic              sample_stb
);
  logic              en;
  logic              busy;
  logic              accept;
  logic              tick;
  logic [CODE_W-1:0] code_q;

  assign en          = cfg_word[CFG_EN_BIT];
  assign start_ready = en && !busy;
  assign accept      = start_valid && start_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (accept) code_q <= cfg_word[CFG_CODE_LSB +: CODE_W];
  end

  spi_half_timer #(.CODE_W(CODE_W), .HALF_W(HALF_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy && en),
    .code    (code_q),
    .tick    (tick)
  );

  spi_edge_seq #(.BITS_W(BITS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .nbits      (start_bits),
    .cpha_in    (cfg_word[CFG_CPHA_BIT]),
    .cpol_in    (cfg_word[CFG_CPOL_BIT]),
    .en         (en),
    .tick       (tick),
    .sclk       (sclk),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb),
    .busy       (busy)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int CFG_W  = 6,
  parameter int BITS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_W-1:0]  cfg_word,
  input logic              start_valid,
  input logic              start_ready,
  input logic [BITS_W-1:0] start_bits,
  input logic              sclk,
  input logic              launch_stb,
  input logic              sample_stb
);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_stb && sample_stb));

  p_sample_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !$stable(sclk));

  p_frozen_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[0] |=> $stable(sclk));

  p_busy_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && start_bits != '0) |=> !start_ready);

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ready && $past(start_ready) && $stable(cfg_word[1])) |-> (sclk == cfg_word[1]));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.CFG_W(CFG_W), .BITS_W(BITS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_word    (cfg_word),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .start_bits  (start_bits),
  .sclk        (sclk),
  .launch_stb  (launch_stb),
  .sample_stb  (sample_stb)
);

// File: tb/spi_sclk_gen_test.sv
`timescale 1ns/1ps
module spi_sclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg = 6'd0;
  logic       sv = 1'b0;
  logic [7:0] nb = 8'd0;
  logic       ready, sclk, l_stb, s_stb;

  always #4 clk = ~clk;

  spi_sclk_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg), .start_valid(sv),
    .start_ready(ready), .start_bits(nb), .sclk(sclk),
    .launch_stb(l_stb), .sample_stb(s_stb)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    finished = 0;
  string req = "R1";

  logic [2:0] q[$];
  logic e_sclk = 1'b0, e_l = 1'b0, e_s = 1'b0;

  function automatic logic [5:0] mk(int code, bit cpha, bit cpol, bit en);
    return {code[2:0], cpha, cpol, en};
  endfunction

  // Expected per-cycle {sclk, launch, sample} for one whole transfer
  function automatic void build(logic [5:0] c, int n);
    int  half = 1 << c[5:3];
    bit  ph = c[2];
    bit  lvl = c[1];
    bit  lo, so;
    q.push_back({lvl, ~ph, 1'b0});
    for (int k = 1; k <= 2 * n; k++) begin
      for (int h = 1; h < half; h++) q.push_back({lvl, 1'b0, 1'b0});
      lvl = ~lvl;
      if (k % 2 == 1) begin lo = ph; so = ~ph; end
      else begin so = ph; lo = ~ph && (k != 2 * n); end
      q.push_back({lvl, lo, so});
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      e_sclk = 1'b0; e_l = 1'b0; e_s = 1'b0;
    end else begin
      e_l = 1'b0; e_s = 1'b0;
      if (cfg[0] && q.size() == 0 && sv && nb != 0) build(cfg, nb);
      if (cfg[0] && q.size() > 0) {e_sclk, e_l, e_s} = q.pop_front();
      else if (cfg[0]) e_sclk = cfg[1];
    end
  end

  task automatic chk(string r, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk(req, "sclk", sclk, e_sclk);
      chk(req, "launch", l_stb, e_l);
      chk(req, "sample", s_stb, e_s);
      chk(req, "ready", ready, cfg[0] && q.size() == 0);
    end
  end

  task automatic report();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_bad++;
      $display("FAIL R6 watchdog act=%0d exp<=100000", cyc);
      report();
    end
  end

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(logic [5:0] c, int n, string r);
    @(negedge clk);
    req = r; cfg = c; sv = 1'b1; nb = 8'(n);
    @(negedge clk);
    sv = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values with master disabled
    chk("R1", "sclk", sclk, 1'b0);
    chk("R1", "launch", l_stb, 1'b0);
    chk("R1", "sample", s_stb, 1'b0);
    chk("R1", "ready", ready, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: idle level follows polarity once enabled
    req = "R3"; cfg = mk(0, 0, 1, 1);
    repeat (3) @(negedge clk);
    cfg = mk(0, 0, 0, 1);
    repeat (3) @(negedge clk);

    xfer(mk(0, 0, 0, 1), 3, "R4");
    xfer(mk(2, 0, 1, 1), 2, "R4");
    xfer(mk(1, 1, 1, 1), 4, "R5");
    xfer(mk(3, 1, 0, 1), 2, "R5");
    xfer(mk(7, 0, 0, 1), 1, "R2");
    xfer(mk(0, 1, 0, 1), 5, "R2");
    xfer(mk(2, 1, 1, 1), 3, "R10");
    xfer(mk(1, 0, 0, 1), 0, "R9");

    // R8: settings changed mid-transfer are ignored
    @(negedge clk);
    req = "R8"; cfg = mk(1, 0, 0, 1); sv = 1'b1; nb = 8'd3;
    @(negedge clk); sv = 1'b0;
    repeat (3) @(negedge clk);
    cfg = mk(5, 1, 1, 1);
    wait_idle();

    // R7: pause mid-transfer, request while disabled is refused
    @(negedge clk);
    req = "R7"; cfg = mk(2, 0, 0, 1); sv = 1'b1; nb = 8'd3;
    @(negedge clk); sv = 1'b0;
    repeat (5) @(negedge clk);
    cfg = mk(2, 0, 1, 0); sv = 1'b1;
    repeat (12) @(negedge clk);
    sv = 1'b0; cfg = mk(2, 0, 0, 1);
    wait_idle();
    cfg = mk(0, 0, 1, 0); sv = 1'b1; nb = 8'd2;
    repeat (6) @(negedge clk);
    sv = 1'b0;
    @(negedge clk);

    // R6: held request runs back-to-back transfers
    req = "R6"; cfg = mk(0, 1, 0, 1); sv = 1'b1; nb = 8'd2;
    repeat (14) @(negedge clk);
    sv = 1'b0;
    wait_idle();

    report();
  end
endmodule